// File: doc/BRIEF.md
# Page-Decoded SPI Bridge Behind a Byte Address Window

This block gives a host with only a narrow byte-wide I/O port a way to drive a serial flash over SPI. The host writes a 32-bit target address one byte at a time into four address registers, then touches a single data port. The data-port access is treated as a memory access at that target address. Two 256-byte pages of the target space have special meaning. A write anywhere in the deselect page raises chip-select. A write in the select page lowers chip-select and shifts the written byte out. A read in the select page lowers chip-select, shifts one byte in and returns it.

A typical host loads the three outer address bytes once. After that it changes only the second byte to move between the two pages. A flash command is then a deselect write, a run of select-page writes, a run of select-page reads, and a final deselect write. While a byte is on the wire, the host port raises wait. Access requests made during wait are not accepted.

Top module: `spi_window_bridge`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, host_wait is 0, and all four address bytes read back as 0x00.
- R2: Host offsets 0..3 store target address bits [7:0], [15:8], [23:16] and [31:24] respectively. A read at offset 0..3 returns the stored byte on host_rdata in the cycle after the read is accepted.
- R3: A data-port write (offset 4) whose target address lies in 0xFFFFFE00..0xFFFFFEFF sets spi_cs_n to 1 by the next cycle. It produces no SCK edge and no wait, whatever the data value.
- R4: A data-port write in 0xFFFFFD00..0xFFFFFDFF sets spi_cs_n to 0 and sends the byte in SPI mode 0, MSB first, with exactly 8 rising SCK edges. MOSI is valid before each rising edge, and spi_cs_n stays 0 for the whole byte.
- R5: A data-port read in 0xFFFFFD00..0xFFFFFDFF sets spi_cs_n to 0, drives MOSI as 0xFF and samples MISO on the 8 rising edges, MSB first. The assembled byte is on host_rdata once host_wait falls.
- R6: For a shifting access, host_wait is 1 for exactly 16*SCK_HALF cycles, starting in the cycle after acceptance. The SCK period is 2*SCK_HALF system clocks.
- R7: A request presented while host_wait is 1 is not accepted. It changes no address byte and starts no transfer.
- R8: A data-port read outside the select page returns 0xFF. A data-port write outside both pages is discarded. Neither changes spi_cs_n, toggles SCK or raises wait.
- R9: Reads at offsets 5..7 return 0x00, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Host port offset (0..3 address bytes, 4 data) |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write request, accepted when host_wait is 0 |
| host_rd | input | 1 | Read request, accepted when host_wait is 0 and host_wr is 0 |
| host_rdata | output | 8 | Registered read data |
| host_wait | output | 1 | Transfer in progress, requests not accepted |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |
| spi_cs_n | output | 1 | Active-low chip-select |

## Verification
The assertions assume a host that issues at most one request per cycle and holds host_addr and host_wdata stable in the cycle a request is presented. They also assume that MISO settles within one SCK half-period after a falling edge. The bench presents one-cycle requests at the falling system-clock edge and waits for host_wait to clear before normal requests. The one exception is the R7 check, where a request is deliberately pushed into a busy window. The bench's slave model changes MISO only on falling SCK edges. The bench sweeps every byte value through both the send and the receive path.

// File: rtl/spiwb_pkg.sv
package spiwb_pkg;
  typedef enum logic [1:0] {
    PG_OTHER    = 2'd0,
    PG_SELECT   = 2'd1,
    PG_DESELECT = 2'd2
  } page_e;
endpackage

// File: rtl/spiwb_addr_regs.sv
module spiwb_addr_regs #(
  parameter int NBYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(NBYTES)-1:0] wr_idx,
  input  logic [7:0]                wr_data,
  input  logic [$clog2(NBYTES)-1:0] rd_idx,
  output logic [7:0]                rd_byte,
  output logic [NBYTES*8-1:0]       addr
);
  localparam int IW = $clog2(NBYTES);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] q;
    logic [7:0] q_nxt;
    always_comb begin
      q_nxt = q;
      if (wr_en && (wr_idx == IW'(g))) q_nxt = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
    end
    assign addr[g*8 +: 8] = q;
  end

  assign rd_byte = addr[rd_idx*8 +: 8];
endmodule

// File: rtl/spiwb_page_decode.sv
module spiwb_page_decode
  import spiwb_pkg::*;
#(
  parameter int              TW        = 24,
  parameter logic [TW-1:0]   SEL_PAGE  = 24'hFFFFFD,
  parameter logic [TW-1:0]   DSEL_PAGE = 24'hFFFFFE
) (
  input  logic [TW-1:0] page_addr,
  output page_e         page
);
  always_comb begin
    if (page_addr == SEL_PAGE)       page = PG_SELECT;
    else if (page_addr == DSEL_PAGE) page = PG_DESELECT;
    else                             page = PG_OTHER;
  end
endmodule

// File: rtl/spiwb_shifter.sv
module spiwb_shifter #(
  parameter int SCK_HALF = 2,
  parameter int BITS     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] tx_byte,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] rx_byte,
  output logic            sck,
  output logic            mosi
);
  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;

  logic            busy_q, busy_n;
  logic            sck_q, sck_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [BW-1:0]   bit_q, bit_n;
  logic [BITS-1:0] tx_q, tx_n;
  logic [BITS-1:0] rx_q, rx_n;
  logic            half_end, last_bit;

  assign half_end = (cnt_q == CW'(SCK_HALF - 1));
  assign last_bit = (bit_q == BW'(BITS - 1));

  always_comb begin
    busy_n = busy_q;
    sck_n  = sck_q;
    cnt_n  = cnt_q;
    bit_n  = bit_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        sck_n  = 1'b0;
        cnt_n  = '0;
        bit_n  = '0;
        tx_n   = tx_byte;
      end
    end else if (half_end) begin
      cnt_n = '0;
      if (!sck_q) begin
        sck_n = 1'b1;
        rx_n  = {rx_q[BITS-2:0], miso};
      end else begin
        sck_n = 1'b0;
        if (last_bit) begin
          busy_n = 1'b0;
          tx_n   = '1;
        end else begin
          bit_n = bit_q + 1'b1;
          tx_n  = {tx_q[BITS-2:0], 1'b1};
        end
      end
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '1;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_n;
      sck_q  <= sck_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
    end
  end

  assign busy    = busy_q;
  assign done    = busy_q & sck_q & half_end & last_bit;
  assign rx_byte = rx_q;
  assign sck     = sck_q;
  assign mosi    = tx_q[BITS-1];

  // Mode 0: data must not move on a rising edge.
  assert_mosi_steady_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> $stable(mosi));
  // A finished byte always leaves the shifter idle.
  assert_done_ends_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
  // Each transfer begins with SCK low.
  assert_start_sck_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !sck_q);
endmodule

// File: rtl/spi_window_bridge.sv
module spi_window_bridge
  import spiwb_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int PAGE_BITS  = 8,
  parameter int SCK_HALF   = 2,
  parameter logic [ADDR_BYTES*8-PAGE_BITS-1:0] SEL_PAGE  = 'hFFFFFD,
  parameter logic [ADDR_BYTES*8-PAGE_BITS-1:0] DSEL_PAGE = 'hFFFFFE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic       host_wr,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  output logic       host_wait,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n
);
  localparam int AW = ADDR_BYTES * 8;
  localparam int IW = $clog2(ADDR_BYTES);
  localparam int TW = AW - PAGE_BITS;
  localparam logic [2:0] DATA_OFS = 3'(ADDR_BYTES);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  logic          wr_acc, rd_acc, is_addr, is_data;
  logic [AW-1:0] addr_word;
  logic [7:0]    reg_byte;
  page_e         page;
  logic          shift_start, shift_busy, shift_done;
  logic [7:0]    shift_tx, shift_rx;

  assign wr_acc  = host_wr & ~shift_busy;
  assign rd_acc  = host_rd & ~host_wr & ~shift_busy;
  assign is_addr = (host_addr < DATA_OFS);
  assign is_data = (host_addr == DATA_OFS);

  spiwb_addr_regs #(.NBYTES(ADDR_BYTES)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .wr_en  (wr_acc & is_addr),
    .wr_idx (host_addr[IW-1:0]),
    .wr_data(host_wdata),
    .rd_idx (host_addr[IW-1:0]),
    .rd_byte(reg_byte),
    .addr   (addr_word)
  );

  spiwb_page_decode #(.TW(TW), .SEL_PAGE(SEL_PAGE), .DSEL_PAGE(DSEL_PAGE)) u_dec (
    .page_addr(addr_word[AW-1:PAGE_BITS]),
    .page     (page)
  );

  assign shift_start = (wr_acc | rd_acc) & is_data & (page == PG_SELECT);
  assign shift_tx    = wr_acc ? host_wdata : 8'hFF;

  spiwb_shifter #(.SCK_HALF(SCK_HALF), .BITS(8)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .start  (shift_start),
    .tx_byte(shift_tx),
    .miso   (spi_miso),
    .busy   (shift_busy),
    .done   (shift_done),
    .rx_byte(shift_rx),
    .sck    (spi_sck),
    .mosi   (spi_mosi)
  );

  logic       cs_n_q, cs_n_n;
  logic       rd_pend_q, rd_pend_n;
  logic [7:0] rdata_q, rdata_n;

  always_comb begin
    cs_n_n    = cs_n_q;
    rd_pend_n = rd_pend_q;
    rdata_n   = rdata_q;
    if (shift_start) begin
      cs_n_n    = 1'b0;
      rd_pend_n = rd_acc;
    end else if (wr_acc && is_data && (page == PG_DESELECT)) begin
      cs_n_n = 1'b1;
    end
    if (rd_acc) begin
      if (is_addr)                  rdata_n = reg_byte;
      else if (!is_data)            rdata_n = 8'h00;
      else if (page != PG_SELECT)   rdata_n = 8'hFF;
    end
    if (shift_done && rd_pend_q) begin
      rdata_n   = shift_rx;
      rd_pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cs_n_q    <= 1'b1;
      rd_pend_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      cs_n_q    <= cs_n_n;
      rd_pend_q <= rd_pend_n;
      rdata_q   <= rdata_n;
    end
  end

  assign spi_cs_n   = cs_n_q;
  assign host_rdata = rdata_q;
  assign host_wait  = shift_busy;

  assert_cs_low_during_byte_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    shift_busy |-> !spi_cs_n);
  assert_wait_freezes_addr_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    host_wait |=> $stable(addr_word));
  assert_no_start_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    shift_busy |-> !shift_start);
  assert_sck_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n_i)
    !shift_busy |-> !spi_sck);
  assert_deselect_no_clock_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(spi_cs_n) |-> !shift_busy);
endmodule

// File: tb/sim_spi_window_bridge.sv
module sim_spi_window_bridge;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic       host_wait;
  logic       spi_sck, spi_mosi, spi_cs_n;
  logic       spi_miso;

  always #10 clk = ~clk;

  spi_window_bridge #(.SCK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .host_wait(host_wait), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // Slave model: MISO moves on falling SCK, MOSI captured on rising SCK.
  logic [7:0] slave_byte = 8'h00;
  logic [2:0] sbit = 3'd0;
  logic [7:0] mcap = 8'h00;
  int         redges = 0;
  assign spi_miso = slave_byte[3'd7 - sbit];
  always @(negedge spi_sck) sbit <= sbit + 3'd1;
  always @(posedge spi_sck) begin
    mcap   <= {mcap[6:0], spi_mosi};
    redges <= redges + 1;
  end

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] ofs, input logic [7:0] d);
    @(negedge clk);
    while (host_wait) @(negedge clk);
    host_addr = ofs; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // Returns the number of sampled cycles spent in wait.
  task automatic idle_wait(output int cyc, output int cs_hi);
    cyc = 0; cs_hi = 0;
    while (host_wait) begin
      cyc++;
      if (spi_cs_n) cs_hi++;
      @(negedge clk);
    end
  endtask

  task automatic hrd(input logic [2:0] ofs, output logic [7:0] d);
    int c, h;
    @(negedge clk);
    while (host_wait) @(negedge clk);
    host_addr = ofs; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    idle_wait(c, h);
    d = host_rdata;
  endtask

  task automatic set_addr(input logic [31:0] a);
    for (int i = 0; i < 4; i++) hwr(3'(i), a[i*8 +: 8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int c, h, e0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1 cs_n in reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1 sck in reset", spi_sck, 0);
    chk(host_wait == 1'b0, "R1 wait in reset", host_wait, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      hrd(3'(i), d);
      chk(d == 8'h00, "R1 address byte after reset", d, 0);
    end

    // R2: address byte store and read-back sweep
    for (int v = 0; v < 256; v += 23) begin
      for (int i = 0; i < 4; i++) hwr(3'(i), 8'(v + i * 61));
      for (int i = 0; i < 4; i++) begin
        hrd(3'(i), d);
        chk(d == 8'(v + i * 61), "R2 address byte readback", d, 8'(v + i * 61));
      end
    end

    // R2/R4: little-endian order, select page hits only with correct mapping
    set_addr(32'hFFFFFD00);
    e0 = redges;
    hwr(3'd4, 8'h3C);
    idle_wait(c, h);
    chk(c == 16 * HALF, "R6 wait length on write", c, 16 * HALF);
    chk(redges - e0 == 8, "R4 rising edges per byte", redges - e0, 8);
    chk(mcap == 8'h3C, "R4 byte on MOSI", mcap, 8'h3C);
    chk(spi_cs_n == 1'b0, "R4 cs low after byte", spi_cs_n, 0);

    // R3: switch only A1 to the deselect page
    hwr(3'd1, 8'hFE);
    e0 = redges;
    hwr(3'd4, 8'hA5);
    chk(spi_cs_n == 1'b1, "R3 cs high after deselect write", spi_cs_n, 1);
    chk(host_wait == 1'b0, "R3 no wait on deselect", host_wait, 0);
    repeat (3) @(negedge clk);
    chk(redges == e0, "R3 no SCK on deselect", redges - e0, 0);
    hrd(3'd4, d);
    chk(d == 8'hFF, "R8 read in deselect page", d, 8'hFF);

    // R4/R6: full write sweep
    hwr(3'd1, 8'hFD);
    for (int v = 0; v < 256; v++) begin
      e0 = redges;
      hwr(3'd4, 8'(v));
      idle_wait(c, h);
      chk(c == 16 * HALF, "R6 wait length", c, 16 * HALF);
      chk(h == 0, "R4 cs stays low", h, 0);
      chk(redges - e0 == 8 && mcap == 8'(v), "R4 MOSI byte", mcap, v);
    end

    // R5: full read sweep
    for (int v = 0; v < 256; v++) begin
      slave_byte = 8'(v);
      e0 = redges;
      hrd(3'd4, d);
      chk(d == 8'(v), "R5 MISO byte returned", d, v);
      chk(mcap == 8'hFF && redges - e0 == 8, "R5 MOSI held 0xFF", mcap, 8'hFF);
      chk(spi_cs_n == 1'b0, "R5 cs low", spi_cs_n, 0);
    end

    // R7: requests during wait are not accepted
    e0 = redges;
    hwr(3'd4, 8'h81);
    chk(host_wait == 1'b1, "R7 wait raised", host_wait, 1);
    host_addr = 3'd1; host_wdata = 8'h22; host_wr = 1'b1;
    @(negedge clk);
    host_addr = 3'd4; host_wdata = 8'h44;
    @(negedge clk);
    host_wr = 1'b0;
    idle_wait(c, h);
    repeat (4) @(negedge clk);
    chk(redges - e0 == 8, "R7 no extra byte", redges - e0, 8);
    chk(mcap == 8'h81, "R7 first byte intact", mcap, 8'h81);
    hrd(3'd1, d);
    chk(d == 8'hFD, "R7 A1 unchanged", d, 8'hFD);

    // R8: outside both pages (cs currently low)
    hwr(3'd1, 8'h12);
    e0 = redges;
    hwr(3'd4, 8'h5A);
    chk(host_wait == 1'b0, "R8 no wait outside", host_wait, 0);
    hrd(3'd4, d);
    chk(d == 8'hFF, "R8 read outside pages", d, 8'hFF);
    chk(spi_cs_n == 1'b0, "R8 cs unchanged", spi_cs_n, 0);
    set_addr(32'h7FFFFE00);
    hwr(3'd4, 8'h00);
    chk(spi_cs_n == 1'b0, "R8 top byte mismatch ignored", spi_cs_n, 0);
    chk(redges == e0, "R8 no SCK outside", redges - e0, 0);

    // R9: unused offsets
    for (int o = 5; o < 8; o++) begin
      hwr(3'(o), 8'hC3);
      hrd(3'(o), d);
      chk(d == 8'h00, "R9 unused offset reads zero", d, 0);
    end
    hrd(3'd3, d);
    chk(d == 8'h7F, "R9 A3 untouched", d, 8'h7F);
    hrd(3'd0, d);
    chk(d == 8'h00, "R9 A0 untouched", d, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule